// File: doc/BRIEF.md
# Bus controller message sequencer

This block runs a bus-controller message list that software has placed in a shared single-port RAM. A start command begins the list. The block reads the current area's stack pointer and message count. For each message it marks the descriptor entry as started and stores a time tag. It then loads the message data block address and hands that address to an external protocol engine with a one-cycle start pulse.

When the engine signals end of message, the block finishes the entry. It writes the final status with the engine's error flags and a fresh time tag. It advances the stack pointer and the message count and writes both back to RAM. It then either starts the next message on its own or stops.

The list length is a ones-complement count, and the list ends when the count reaches all ones. Interrupt pulses for each message, for errors and for list completion go out through a mask. Software can prepare one RAM area while the block works from the other. An optional stop-on-error mode halts the list after a failed message.

Top module: `bc_msg_seq`

## Requirements
- R1: After reset the block performs no RAM access and drives no start pulse and no interrupt pulse.
- R2: On a start command the block reads the stack pointer and the message count of the current area. Area A uses RAM 0x0100 and 0x0101, area B uses 0x0104 and 0x0105, and `area_sel_i`=1 selects B. It then writes 0x4000 (bit 14, started) to entry word 0 and `time_tag_i` to word 1, and reads word 3. It presents word 3 on `blk_addr_o` during a one-cycle `eng_start_o` pulse and holds it there until end of message. The RAM sees at most one access per cycle.
- R3: A pulse on `eng_eom_i` while the block waits for the engine makes entry word 0 hold bit 15 (ended), the four `eng_err_i` flags in bits 3:0, and bit 12 set when any flag is set. Word 1 is rewritten with the current `time_tag_i`.
- R4: After every message, with or without error, the stack pointer advances by 4 and is written back to its pointer location. Its low 8 bits wrap while its upper bits are kept, so 0x00FC becomes 0x0000 and 0x0FFC becomes 0x0F00.
- R5: The message count is incremented after each message and written back. The list is done when it reaches 0xFFFF. Otherwise the next message starts with no new command. A count already at 0xFFFF on start runs no message and writes nothing.
- R6: `irq_mask_i` bit 0 enables a one-cycle pulse on `irq_eom_o` after every message. Bit 1 enables `irq_err_o` after a message with any error flag. Bit 2 enables `irq_done_o` when the count reaches 0xFFFF, including the empty-list case. A mask bit of 0 suppresses its pulse.
- R7: With `stop_on_err_i` set, a message that ends with an error completes its update and write-back, and then the block halts. The pointer is left on the next entry, and a new start command continues the list from there.
- R8: A change of `area_sel_i` while a message is in progress takes effect only for the following message. The message in progress completes all its writes in the old area.
- R9: A start command while a list is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start command pulse |
| area_sel_i | input | 1 | Current area select, 1 = area B |
| stop_on_err_i | input | 1 | Halt the list after a message with errors |
| irq_mask_i | input | 3 | Interrupt enables: bit 0 end of message, bit 1 error, bit 2 list done |
| time_tag_i | input | 16 | Time tag value to store |
| mem_addr_o | output | 16 | RAM word address |
| mem_we_o | output | 1 | RAM write strobe |
| mem_re_o | output | 1 | RAM read strobe, data returned next cycle |
| mem_wdata_o | output | 16 | RAM write data |
| mem_rdata_i | input | 16 | RAM read data |
| eng_start_o | output | 1 | Start pulse to the protocol engine |
| blk_addr_o | output | 16 | Message data block address for the engine |
| eng_eom_i | input | 1 | End-of-message pulse from the engine |
| eng_err_i | input | 4 | Error flags valid with `eng_eom_i` |
| irq_eom_o | output | 1 | Per-message interrupt pulse |
| irq_err_o | output | 1 | Error interrupt pulse |
| irq_done_o | output | 1 | List-done interrupt pulse |

## Verification
The sequencer runs lists of one, two and three messages, both clean and with error flags. These separate the automatic chaining from the final-message exit, and show that each status word carries its own flags. Start pointers near the top of the stack window in both areas show the low-byte wrap apart from a plain add. A halt on an error, followed by a restart, shows the pointer and count left on the next message. Three further cases cover the remaining paths: an area flip during a message, an empty list, and a start pulse during a message. Together they show area hold-off, the zero-message path and the ignored command. Partial masks show that each interrupt line is gated on its own.

// File: rtl/bc_seq_pkg.sv
package bc_seq_pkg;
  localparam int DW    = 16;
  localparam int ERR_W = 4;
  localparam int MSK_W = 3;

  typedef logic [DW-1:0] word_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_SP, S_CAP_SP, S_CAP_CNT, S_WR_SOM, S_WR_TT1, S_RD_BLK,
    S_CAP_BLK, S_GO, S_WAIT, S_WR_EOM, S_WR_TT2, S_WR_SP, S_WR_CNT
  } seq_st_e;

  localparam int BSW_EOM = 15;
  localparam int BSW_SOM = 14;
  localparam int BSW_ERR = 12;

  // status word of a descriptor entry
  function automatic word_t bsw_make(logic som, logic eom, logic [ERR_W-1:0] err);
    word_t w;
    w = '0;
    w[BSW_SOM] = som;
    w[BSW_EOM] = eom;
    w[BSW_ERR] = |err;
    w[ERR_W-1:0] = err;
    return w;
  endfunction

  // pointer step inside a wrapping window, upper bits kept
  function automatic word_t sp_advance(word_t sp, word_t wrap_mask, word_t step);
    word_t sum;
    sum = sp + step;
    return (sp & ~wrap_mask) | (sum & wrap_mask);
  endfunction

  // ones-complement count is exhausted at all ones
  function automatic logic cnt_exhausted(word_t c);
    return &c;
  endfunction
endpackage

// File: rtl/bc_seq_ctrl.sv
module bc_seq_ctrl
  import bc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    eom_i,
  input  logic    cnt_rd_done_i,
  input  logic    cnt_nx_done_i,
  input  logic    halt_req_i,
  output seq_st_e state_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (start_i) st_d = S_RD_SP;
      S_RD_SP:   st_d = S_CAP_SP;
      S_CAP_SP:  st_d = S_CAP_CNT;
      S_CAP_CNT: st_d = cnt_rd_done_i ? S_IDLE : S_WR_SOM;
      S_WR_SOM:  st_d = S_WR_TT1;
      S_WR_TT1:  st_d = S_RD_BLK;
      S_RD_BLK:  st_d = S_CAP_BLK;
      S_CAP_BLK: st_d = S_GO;
      S_GO:      st_d = S_WAIT;
      S_WAIT:    if (eom_i) st_d = S_WR_EOM;
      S_WR_EOM:  st_d = S_WR_TT2;
      S_WR_TT2:  st_d = S_WR_SP;
      S_WR_SP:   st_d = S_WR_CNT;
      S_WR_CNT:  st_d = (cnt_nx_done_i || halt_req_i) ? S_IDLE : S_RD_SP;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/bc_seq_regs.sv
module bc_seq_regs
  import bc_seq_pkg::*;
#(
  parameter word_t PTR_BASE    = 16'h0100,
  parameter word_t AREA_STRIDE = 16'h0004,
  parameter word_t WRAP_MASK   = 16'h00FF,
  parameter word_t STEP        = 16'h0004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_st_e          state_i,
  input  logic             area_sel_i,
  input  logic             eom_i,
  input  logic [ERR_W-1:0] eom_err_i,
  input  word_t            time_tag_i,
  input  word_t            mem_rdata_i,
  output word_t            mem_addr_o,
  output word_t            mem_wdata_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output word_t            blk_addr_o,
  output logic [ERR_W-1:0] err_o,
  output logic             area_o,
  output logic             cnt_rd_done_o,
  output logic             cnt_nx_done_o
);
  localparam word_t OFS_CNT = 16'd1;
  localparam word_t OFS_TT  = 16'd1;
  localparam word_t OFS_BLK = 16'd3;

  word_t            sp_q, cnt_q, blk_q;
  logic [ERR_W-1:0] err_q;
  logic             area_q;
  word_t            base, sp_nx, cnt_nx;

  assign base   = PTR_BASE + (area_q ? AREA_STRIDE : '0);
  assign sp_nx  = sp_advance(sp_q, WRAP_MASK, STEP);
  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      cnt_q  <= '0;
      blk_q  <= '0;
      err_q  <= '0;
      area_q <= 1'b0;
    end else begin
      // area follows the select only between messages
      if (state_i == S_IDLE || state_i == S_WR_CNT) area_q <= area_sel_i;
      if (state_i == S_CAP_SP)  sp_q  <= mem_rdata_i;
      if (state_i == S_CAP_CNT) cnt_q <= mem_rdata_i;
      if (state_i == S_CAP_BLK) blk_q <= mem_rdata_i;
      if (state_i == S_WR_SOM)  err_q <= '0;
      if (state_i == S_WAIT && eom_i) err_q <= eom_err_i;
      if (state_i == S_WR_SP)   sp_q  <= sp_nx;
      if (state_i == S_WR_CNT)  cnt_q <= cnt_nx;
    end
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    unique case (state_i)
      S_RD_SP:  begin mem_re_o = 1'b1; mem_addr_o = base; end
      S_CAP_SP: begin mem_re_o = 1'b1; mem_addr_o = base + OFS_CNT; end
      S_WR_SOM: begin
        mem_we_o = 1'b1; mem_addr_o = sp_q;
        mem_wdata_o = bsw_make(1'b1, 1'b0, '0);
      end
      S_WR_TT1: begin mem_we_o = 1'b1; mem_addr_o = sp_q + OFS_TT; mem_wdata_o = time_tag_i; end
      S_RD_BLK: begin mem_re_o = 1'b1; mem_addr_o = sp_q + OFS_BLK; end
      S_WR_EOM: begin
        mem_we_o = 1'b1; mem_addr_o = sp_q;
        mem_wdata_o = bsw_make(1'b0, 1'b1, err_q);
      end
      S_WR_TT2: begin mem_we_o = 1'b1; mem_addr_o = sp_q + OFS_TT; mem_wdata_o = time_tag_i; end
      S_WR_SP:  begin mem_we_o = 1'b1; mem_addr_o = base; mem_wdata_o = sp_nx; end
      S_WR_CNT: begin mem_we_o = 1'b1; mem_addr_o = base + OFS_CNT; mem_wdata_o = cnt_nx; end
      default: ;
    endcase
  end

  assign blk_addr_o    = blk_q;
  assign err_o         = err_q;
  assign area_o        = area_q;
  assign cnt_rd_done_o = cnt_exhausted(mem_rdata_i);
  assign cnt_nx_done_o = cnt_exhausted(cnt_nx);
endmodule

// File: rtl/bc_seq_irq.sv
module bc_seq_irq
  import bc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MSK_W-1:0] mask_i,
  input  logic [MSK_W-1:0] evt_i,
  output logic [MSK_W-1:0] irq_o
);
  logic [MSK_W-1:0] pulse_q;

  for (genvar i = 0; i < MSK_W; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[i] <= 1'b0;
      else        pulse_q[i] <= evt_i[i] & mask_i[i];
    end
  end

  assign irq_o = pulse_q;
endmodule

// File: rtl/bc_msg_seq.sv
module bc_msg_seq
  import bc_seq_pkg::*;
#(
  parameter logic [15:0] PTR_BASE      = 16'h0100,
  parameter logic [15:0] AREA_STRIDE   = 16'h0004,
  parameter int          STACK_ENTRIES = 64,
  parameter int          ENTRY_WORDS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        area_sel_i,
  input  logic        stop_on_err_i,
  input  logic [2:0]  irq_mask_i,
  input  logic [15:0] time_tag_i,
  output logic [15:0] mem_addr_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [15:0] mem_wdata_o,
  input  logic [15:0] mem_rdata_i,
  output logic        eng_start_o,
  output logic [15:0] blk_addr_o,
  input  logic        eng_eom_i,
  input  logic [3:0]  eng_err_i,
  output logic        irq_eom_o,
  output logic        irq_err_o,
  output logic        irq_done_o
);
  localparam int    WRAP_SPAN = STACK_ENTRIES * ENTRY_WORDS;
  localparam word_t WRAP_MASK = word_t'(WRAP_SPAN - 1);
  localparam word_t STEP      = word_t'(ENTRY_WORDS);

  seq_st_e          state;
  logic [ERR_W-1:0] err_q;
  logic             cur_area;
  logic             cnt_rd_done, cnt_nx_done;
  logic [MSK_W-1:0] irq_vec;

  // named internal events
  logic msg_end_evt, err_evt, list_done_evt, wait_st, msg_active, halt_req;

  assign msg_end_evt   = (state == S_WR_CNT);
  assign err_evt       = msg_end_evt && (|err_q);
  assign list_done_evt = (msg_end_evt && cnt_nx_done) || (state == S_CAP_CNT && cnt_rd_done);
  assign wait_st       = (state == S_WAIT);
  assign msg_active    = (state != S_IDLE) && (state != S_WR_CNT);
  assign halt_req      = stop_on_err_i && (|err_q);

  bc_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .eom_i        (eng_eom_i),
    .cnt_rd_done_i(cnt_rd_done),
    .cnt_nx_done_i(cnt_nx_done),
    .halt_req_i   (halt_req),
    .state_o      (state)
  );

  bc_seq_regs #(
    .PTR_BASE   (PTR_BASE),
    .AREA_STRIDE(AREA_STRIDE),
    .WRAP_MASK  (WRAP_MASK),
    .STEP       (STEP)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_i      (state),
    .area_sel_i   (area_sel_i),
    .eom_i        (eng_eom_i),
    .eom_err_i    (eng_err_i),
    .time_tag_i   (time_tag_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_we_o     (mem_we_o),
    .mem_re_o     (mem_re_o),
    .blk_addr_o   (blk_addr_o),
    .err_o        (err_q),
    .area_o       (cur_area),
    .cnt_rd_done_o(cnt_rd_done),
    .cnt_nx_done_o(cnt_nx_done)
  );

  bc_seq_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .mask_i(irq_mask_i),
    .evt_i ({list_done_evt, err_evt, msg_end_evt}),
    .irq_o (irq_vec)
  );

  assign eng_start_o = (state == S_GO);
  assign irq_eom_o   = irq_vec[0];
  assign irq_err_o   = irq_vec[1];
  assign irq_done_o  = irq_vec[2];
endmodule

// File: rtl/bc_msg_seq_chk.sv
module bc_msg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_start_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic        irq_done_o,
  input logic [15:0] blk_addr_o,
  input logic        wait_st,
  input logic        msg_active,
  input logic        cur_area
);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  // R2
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R2
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_st && $past(wait_st)) |-> $stable(blk_addr_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done_o |=> !irq_done_o);

  // R8
  area_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_active && $past(msg_active)) |-> $stable(cur_area));
endmodule

bind bc_msg_seq bc_msg_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eng_start_o(eng_start_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .irq_done_o (irq_done_o),
  .blk_addr_o (blk_addr_o),
  .wait_st    (wait_st),
  .msg_active (msg_active),
  .cur_area   (cur_area)
);

// File: tb/bc_msg_seq_bench.sv
`timescale 1ns/1ps
module bc_msg_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, area_sel_i = 1'b0, stop_on_err_i = 1'b0;
  logic [2:0]  irq_mask_i = 3'b111;
  logic [15:0] time_tag_i = 16'h0;
  logic [15:0] mem_addr_o, mem_wdata_o, blk_addr_o;
  logic [15:0] mem_rdata = 16'h0;
  logic        mem_we_o, mem_re_o, eng_start_o;
  logic        eng_eom_i = 1'b0;
  logic [3:0]  eng_err_i = 4'h0;
  logic        irq_eom_o, irq_err_o, irq_done_o;

  logic [15:0] ram [0:4095];
  logic        tb_we = 1'b0;
  logic [15:0] tb_addr = 16'h0, tb_wdata = 16'h0;

  int n_tests = 0, n_fail = 0;
  int n_eom = 0, n_err = 0, n_done = 0, n_start = 0, n_we = 0;

  always #5 clk = ~clk;

  bc_msg_seq u_bc_msg_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .area_sel_i(area_sel_i),
    .stop_on_err_i(stop_on_err_i), .irq_mask_i(irq_mask_i), .time_tag_i(time_tag_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .eng_start_o(eng_start_o),
    .blk_addr_o(blk_addr_o), .eng_eom_i(eng_eom_i), .eng_err_i(eng_err_i),
    .irq_eom_o(irq_eom_o), .irq_err_o(irq_err_o), .irq_done_o(irq_done_o)
  );

  // single-port RAM, one process owns the array
  always @(posedge clk) begin
    if (mem_we_o)   ram[mem_addr_o[11:0]] <= mem_wdata_o;
    else if (tb_we) ram[tb_addr[11:0]] <= tb_wdata;
    if (mem_re_o)   mem_rdata <= ram[mem_addr_o[11:0]];
  end

  always @(negedge clk) begin
    if (irq_eom_o)   n_eom++;
    if (irq_err_o)   n_err++;
    if (irq_done_o)  n_done++;
    if (eng_start_o) n_start++;
    if (mem_we_o)    n_we++;
  end

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[15:8], s[7:0] + 8'd4};
  endfunction

  function automatic logic [15:0] exp_bsw(input logic [3:0] e);
    return (e != 4'h0) ? (16'h9000 | {12'h0, e}) : 16'h8000;
  endfunction

  function automatic logic [15:0] mr(input logic [15:0] a);
    return ram[a[11:0]];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    tb_we = 1'b1; tb_addr = a; tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clr();
    n_eom = 0; n_err = 0; n_done = 0; n_start = 0; n_we = 0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic prep(input logic area, input logic [15:0] sp0, input logic [15:0] cnt,
                      input int n, input logic [15:0] blk0);
    logic [15:0] p, s;
    p = area ? 16'h0104 : 16'h0100;
    wr(p, sp0);
    wr(p + 16'd1, cnt);
    s = sp0;
    for (int i = 0; i < n; i++) begin
      wr(s, 16'h5555);
      wr(s + 16'd3, blk0 + 16'(16 * i));
      s = nxt(s);
    end
  endtask

  task automatic go(input logic area);
    area_sel_i = area;
    time_tag_i = 16'h1000;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_go(input string req, input logic [15:0] exp_blk);
    while (!eng_start_o) @(negedge clk);
    chk(req, blk_addr_o, exp_blk);
  endtask

  task automatic end_msg(input logic [3:0] e, input logic [15:0] tt_end, input logic [15:0] tt_nx);
    repeat (2) @(negedge clk);
    time_tag_i = tt_end; eng_err_i = e; eng_eom_i = 1'b1;
    @(negedge clk);
    eng_eom_i = 1'b0; eng_err_i = 4'h0;
    repeat (3) @(negedge clk);
    time_tag_i = tt_nx;
  endtask

  // serve n messages; message i takes error nibble errs[4i+:4]
  task automatic serve(input logic [15:0] sp0, input int n, input logic [15:0] blk0,
                       input logic [15:0] errs, input bit poke);
    logic [15:0] s;
    s = sp0;
    for (int i = 0; i < n; i++) begin
      wait_go("R2 block address", blk0 + 16'(16 * i));
      chk("R2 started status", mr(s), 16'h4000);
      chk("R2 start time tag", mr(s + 16'd1), 16'h1000 + 16'(i));
      if (poke) begin
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      end
      end_msg(errs[4*i +: 4], 16'h2000 + 16'(i), 16'h1000 + 16'(i + 1));
      s = nxt(s);
    end
  endtask

  task automatic verify(input logic [15:0] sp0, input int n, input logic [15:0] errs);
    logic [15:0] s;
    s = sp0;
    for (int i = 0; i < n; i++) begin
      chk("R3 ended status", mr(s), exp_bsw(errs[4*i +: 4]));
      chk("R3 end time tag", mr(s + 16'd1), 16'h2000 + 16'(i));
      s = nxt(s);
    end
  endtask

  task automatic t_reset();
    chk("R1 start idle", eng_start_o, 0);
    chk("R1 irq idle", {irq_eom_o, irq_err_o, irq_done_o}, 0);
    chk("R1 no ram access", {mem_we_o, mem_re_o}, 0);
  endtask

  task automatic t_basic();
    wr(16'h0104, 16'h0F00);
    prep(1'b0, 16'h0040, 16'hFFFC, 3, 16'h0200);
    clr(); go(1'b0);
    serve(16'h0040, 3, 16'h0200, 16'h0000, 1'b0);
    settle();
    verify(16'h0040, 3, 16'h0000);
    chk("R4 pointer writeback", mr(16'h0100), 16'h004C);
    chk("R5 count writeback", mr(16'h0101), 16'hFFFF);
    chk("R5 auto chaining", n_start, 3);
    chk("R6 eom pulses", n_eom, 3);
    chk("R6 no err pulse", n_err, 0);
    chk("R6 one done pulse", n_done, 1);
    chk("R2 area B untouched", mr(16'h0104), 16'h0F00);
  endtask

  task automatic t_errors();
    prep(1'b0, 16'h0080, 16'hFFFD, 2, 16'h0300);
    clr(); go(1'b0);
    serve(16'h0080, 2, 16'h0300, 16'h0005, 1'b0);
    settle();
    verify(16'h0080, 2, 16'h0005);
    chk("R4 advance despite error", mr(16'h0100), 16'h0088);
    chk("R6 err pulse", n_err, 1);
    chk("R5 continues after error", n_start, 2);
    chk("R6 done after errors", n_done, 1);
  endtask

  task automatic t_stop();
    stop_on_err_i = 1'b1;
    prep(1'b0, 16'h00A0, 16'hFFFC, 3, 16'h0400);
    clr(); go(1'b0);
    serve(16'h00A0, 1, 16'h0400, 16'h0008, 1'b0);
    settle();
    chk("R7 halted", n_start, 1);
    chk("R7 status written", mr(16'h00A0), 16'h9008);
    chk("R7 pointer on next", mr(16'h0100), 16'h00A4);
    chk("R7 count updated", mr(16'h0101), 16'hFFFD);
    chk("R7 no done", n_done, 0);
    chk("R7 err pulse", n_err, 1);
    clr(); go(1'b0);
    serve(16'h00A4, 2, 16'h0410, 16'h0000, 1'b0);
    settle();
    verify(16'h00A4, 2, 16'h0000);
    chk("R7 resumed pointer", mr(16'h0100), 16'h00AC);
    chk("R7 resumed count", mr(16'h0101), 16'hFFFF);
    chk("R7 resumed done", n_done, 1);
    stop_on_err_i = 1'b0;
  endtask

  task automatic t_wrap();
    prep(1'b0, 16'h00FC, 16'hFFFD, 2, 16'h0500);
    clr(); go(1'b0);
    serve(16'h00FC, 2, 16'h0500, 16'h0000, 1'b0);
    settle();
    verify(16'h00FC, 2, 16'h0000);
    chk("R4 wrap area A", mr(16'h0100), 16'h0004);
    prep(1'b1, 16'h0FFC, 16'hFFFE, 1, 16'h0600);
    clr(); go(1'b1);
    serve(16'h0FFC, 1, 16'h0600, 16'h0000, 1'b0);
    settle();
    chk("R4 wrap area B", mr(16'h0104), 16'h0F00);
    chk("R5 count area B", mr(16'h0105), 16'hFFFF);
    chk("R2 area A untouched", mr(16'h0100), 16'h0004);
    area_sel_i = 1'b0;
  endtask

  task automatic t_area_switch();
    prep(1'b0, 16'h0010, 16'hFFFD, 1, 16'h0A00);
    prep(1'b1, 16'h0F20, 16'hFFFE, 1, 16'h0B00);
    clr(); go(1'b0);
    wait_go("R8 first block", 16'h0A00);
    area_sel_i = 1'b1;
    end_msg(4'h0, 16'h2000, 16'h1001);
    wait_go("R8 second block from B", 16'h0B00);
    end_msg(4'h0, 16'h2001, 16'h1002);
    settle();
    chk("R8 A pointer", mr(16'h0100), 16'h0014);
    chk("R8 A count", mr(16'h0101), 16'hFFFE);
    chk("R8 A entry ended", mr(16'h0010), 16'h8000);
    chk("R8 B pointer", mr(16'h0104), 16'h0F24);
    chk("R8 B count", mr(16'h0105), 16'hFFFF);
    chk("R8 B entry ended", mr(16'h0F20), 16'h8000);
    chk("R8 done once", n_done, 1);
    area_sel_i = 1'b0;
  endtask

  task automatic t_masks();
    irq_mask_i = 3'b010;
    prep(1'b0, 16'h0020, 16'hFFFE, 1, 16'h0700);
    clr(); go(1'b0);
    serve(16'h0020, 1, 16'h0700, 16'h0002, 1'b0);
    settle();
    chk("R6 masked eom", n_eom, 0);
    chk("R6 err enabled", n_err, 1);
    chk("R6 masked done", n_done, 0);
    chk("R3 status under mask", mr(16'h0020), 16'h9002);
    irq_mask_i = 3'b100;
    prep(1'b0, 16'h0024, 16'hFFFE, 1, 16'h0710);
    clr(); go(1'b0);
    serve(16'h0024, 1, 16'h0710, 16'h0001, 1'b0);
    settle();
    chk("R6 only done", {n_eom[7:0], n_err[7:0], n_done[7:0]}, 24'h000001);
    irq_mask_i = 3'b111;
  endtask

  task automatic t_empty();
    wr(16'h0100, 16'h0030);
    wr(16'h0101, 16'hFFFF);
    wr(16'h0030, 16'h5555);
    clr(); go(1'b0);
    settle();
    chk("R5 empty no start", n_start, 0);
    chk("R5 empty no writes", n_we, 0);
    chk("R5 empty done pulse", n_done, 1);
    chk("R5 empty entry kept", mr(16'h0030), 16'h5555);
  endtask

  task automatic t_busy_start();
    prep(1'b0, 16'h0060, 16'hFFFE, 1, 16'h0800);
    clr(); go(1'b0);
    serve(16'h0060, 1, 16'h0800, 16'h0000, 1'b1);
    settle();
    chk("R9 start ignored", n_start, 1);
    chk("R9 pointer", mr(16'h0100), 16'h0064);
    chk("R9 done once", n_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_errors();
    t_stop();
    t_wrap();
    t_area_switch();
    t_masks();
    t_empty();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule